// File: doc/BRIEF.md
# Asynchronous static RAM access sequencer

This block sits between an on-chip request port and an external asynchronous static RAM of 32768 bytes. It has a 15-bit address and 8-bit data. Each accepted request becomes one single-byte read or write on the memory pins. The block drives the active-low select, output-enable and write-strobe lines. It also drives a split data bus: outgoing data, incoming data, and a drive-enable for the bidirectional pad.

The memory itself has no clock. The block therefore times every phase by counting clock cycles. Each minimum from the memory's timing table is converted into cycles at build time by rounding up nanoseconds divided by the clock period, which is a parameter. Address and write data are captured when a request is accepted and are held on the pins for the whole access. A write ends when select and write strobe rise together. The pad keeps driving the data for one further cycle so the data hold time is met.

After a read, the block holds off any new access for a release window. This gives the memory time to stop driving the shared bus before the controller drives it. Between accesses all three strobes stay high, so the memory is deselected and in standby.

Top module: `sram_ctl`

## Requirements
- R1: Out of reset and whenever `req_ready` is 1, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_dq_oe` is 0 and `rsp_valid` is 0.
- R2: A read (`req_we`=0) holds `mem_ce_n`=0, `mem_oe_n`=0 and `mem_we_n`=1 for exactly RD_CYC cycles. RD_CYC is the largest of the read cycle time, address access time and output-enable access time, each divided by the clock period and rounded up (5 cycles at 10 ns with the default 45/45/25 ns).
- R3: A read returns the value on `mem_dq_in` at the clock edge where `mem_oe_n` rises, as `rsp_data`, with `rsp_valid` high for exactly one cycle.
- R4: After a read, `req_ready` stays 0 and the strobes stay high for FLT_CYC cycles, counted from the cycle in which `rsp_valid` is high. FLT_CYC is the larger of the rounded-up bus release time and the `TURN_CYC` parameter.
- R5: A write holds `mem_ce_n`=0 and `mem_we_n`=0, with `mem_oe_n`=1 and `mem_dq_oe`=1, for exactly WR_CYC cycles. WR_CYC is the largest of the rounded-up strobe width, data setup and address setup, and one less than the rounded-up write cycle time (4 cycles at 10 ns with the defaults).
- R6: A write ends with `mem_ce_n` and `mem_we_n` rising in the same cycle, while `mem_dq_oe` stays 1 for that one further cycle.
- R7: `mem_dq_oe` is never 1 while `mem_oe_n` is 0, and `mem_we_n` is never 0 while `mem_oe_n` is 0.
- R8: `mem_addr` is stable while `mem_ce_n` stays low, and `mem_dq_out` is stable while `mem_dq_oe` stays high. Changes on `req_addr` or `req_wdata` after acceptance have no effect on the access.
- R9: A request is taken only on a cycle with `req_valid` and `req_ready` both 1, and `mem_ce_n` falls in the next cycle. A request held during a busy period waits and is then carried out once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_data | output | DATA_W | Read data |
| mem_addr | output | ADDR_W | Memory address pins |
| mem_ce_n | output | 1 | Memory select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_dq_out | output | DATA_W | Data toward the pad |
| mem_dq_in | input | DATA_W | Data from the pad |
| mem_dq_oe | output | 1 | Pad drive enable |

## Verification
The bench builds the block with a 10 ns period and the default nanosecond figures, so every access phase lasts several cycles and the rounding up is visible. With a 45 ns access time, the result is 5 cycles rather than 4. The turnaround parameter is set to 3, above the 2-cycle bus release figure, so the bench can tell whether the release window uses the larger of the two. The bench's memory model returns a poison byte until the access time has elapsed, so a read that samples too early returns wrong data.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_READ,
    PH_FLOAT,
    PH_WRITE,
    PH_HOLD
  } phase_e;

  // nanoseconds to whole cycles, rounding up
  function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned period);
    return (ns + period - 1) / period;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctl_cnt.sv
module sram_ctl_cnt #(
  parameter int unsigned CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
  import sram_ctl_pkg::*;
#(
  parameter int unsigned CW      = 3,
  parameter int unsigned RD_CYC  = 5,
  parameter int unsigned WR_CYC  = 4,
  parameter int unsigned FLT_CYC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_we,
  input  logic          cnt_done,
  output phase_e        phase_q,
  output phase_e        phase_d,
  output logic          accept,
  output logic          cnt_load,
  output logic [CW-1:0] cnt_val
);
  localparam logic [CW-1:0] RD_V  = CW'(RD_CYC - 1);
  localparam logic [CW-1:0] WR_V  = CW'(WR_CYC - 1);
  localparam logic [CW-1:0] FLT_V = CW'(FLT_CYC - 1);

  always_comb begin
    phase_d  = phase_q;
    accept   = 1'b0;
    cnt_load = 1'b0;
    cnt_val  = '0;
    unique case (phase_q)
      PH_IDLE: if (req_valid) begin
        accept   = 1'b1;
        cnt_load = 1'b1;
        if (req_we) begin phase_d = PH_WRITE; cnt_val = WR_V; end
        else        begin phase_d = PH_READ;  cnt_val = RD_V; end
      end
      PH_READ: if (cnt_done) begin
        phase_d  = PH_FLOAT;
        cnt_load = 1'b1;
        cnt_val  = FLT_V;
      end
      PH_FLOAT: if (cnt_done) phase_d = PH_IDLE;
      PH_WRITE: if (cnt_done) phase_d = PH_HOLD;
      PH_HOLD:  phase_d = PH_IDLE;
      default:  phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end
endmodule

// File: rtl/sram_ctl_pins.sv
module sram_ctl_pins
  import sram_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            phase_q,
  input  phase_e            phase_d,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic              ce_n_q,
  output logic              oe_n_q,
  output logic              we_n_q,
  output logic [DATA_W-1:0] dout_q,
  output logic              doe_q,
  output logic              rvld_q,
  output logic [DATA_W-1:0] rdata_q
);
  logic ce_n_d, oe_n_d, we_n_d, doe_d, rvld_d;

  always_comb begin
    ce_n_d = !(phase_d == PH_READ || phase_d == PH_WRITE);
    oe_n_d = (phase_d != PH_READ);
    we_n_d = (phase_d != PH_WRITE);
    doe_d  = (phase_d == PH_WRITE || phase_d == PH_HOLD);
    rvld_d = (phase_q == PH_READ) && (phase_d == PH_FLOAT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_n_q <= 1'b1;
      oe_n_q <= 1'b1;
      we_n_q <= 1'b1;
      doe_q  <= 1'b0;
      rvld_q <= 1'b0;
    end else begin
      ce_n_q <= ce_n_d;
      oe_n_q <= oe_n_d;
      we_n_q <= we_n_d;
      doe_q  <= doe_d;
      rvld_q <= rvld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      dout_q <= '0;
    end else if (accept) begin
      addr_q <= req_addr;
      dout_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (rvld_d) rdata_q <= dq_in;
  end

  // R7: no pad drive, and no write strobe, while the memory output is enabled
  a_r7_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    !(doe_q && !oe_n_q) && !(!we_n_q && !oe_n_q));
  // R5: write strobe only inside a selected cycle
  a_r5_we_inside_ce: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n_q |-> !ce_n_q);
  // R6: strobe and select end together, data still driven
  a_r6_end_with_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n_q) |-> (ce_n_q && doe_q));
  // R8: address and outgoing data held steady
  a_r8_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n_q && $past(!ce_n_q)) |-> $stable(addr_q));
  a_r8_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (doe_q && $past(doe_q)) |-> $stable(dout_q));
  // R3: read strobe is a single-cycle pulse
  a_r3_rvld_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rvld_q |=> !rvld_q);
endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W        = 15,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned CLK_PERIOD_NS = 10,
  parameter int unsigned T_RC_NS       = 45,
  parameter int unsigned T_AA_NS       = 45,
  parameter int unsigned T_OE_NS       = 25,
  parameter int unsigned T_WC_NS       = 45,
  parameter int unsigned T_WP_NS       = 25,
  parameter int unsigned T_DS_NS       = 20,
  parameter int unsigned T_AW_NS       = 25,
  parameter int unsigned T_HZ_NS       = 20,
  parameter int unsigned TURN_CYC      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              mem_dq_oe
);
  localparam int unsigned RD_CYC = umax(1, umax(ns2cyc(T_RC_NS, CLK_PERIOD_NS),
                                   umax(ns2cyc(T_AA_NS, CLK_PERIOD_NS), ns2cyc(T_OE_NS, CLK_PERIOD_NS))));
  localparam int unsigned WR_CYC = umax(1, umax(umax(ns2cyc(T_WP_NS, CLK_PERIOD_NS), ns2cyc(T_DS_NS, CLK_PERIOD_NS)),
                                   umax(ns2cyc(T_AW_NS, CLK_PERIOD_NS), ns2cyc(T_WC_NS, CLK_PERIOD_NS) - 1)));
  localparam int unsigned FLT_CYC = umax(1, umax(ns2cyc(T_HZ_NS, CLK_PERIOD_NS), TURN_CYC));
  localparam int unsigned MAX_CYC = umax(umax(RD_CYC, WR_CYC), FLT_CYC);
  localparam int unsigned CW      = $clog2(MAX_CYC + 1);

  phase_e          phase_q, phase_d;
  logic            accept, cnt_load, cnt_done;
  logic [CW-1:0]   cnt_val;

  sram_ctl_seq #(.CW(CW), .RD_CYC(RD_CYC), .WR_CYC(WR_CYC), .FLT_CYC(FLT_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .cnt_done(cnt_done), .phase_q(phase_q), .phase_d(phase_d),
    .accept(accept), .cnt_load(cnt_load), .cnt_val(cnt_val)
  );

  sram_ctl_cnt #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_val), .done(cnt_done)
  );

  sram_ctl_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk(clk), .rst_n(rst_n), .phase_q(phase_q), .phase_d(phase_d),
    .accept(accept), .req_addr(req_addr), .req_wdata(req_wdata), .dq_in(mem_dq_in),
    .addr_q(mem_addr), .ce_n_q(mem_ce_n), .oe_n_q(mem_oe_n), .we_n_q(mem_we_n),
    .dout_q(mem_dq_out), .doe_q(mem_dq_oe), .rvld_q(rsp_valid), .rdata_q(rsp_data)
  );

  assign req_ready = (phase_q == PH_IDLE);

  // R1: standby whenever a request could be taken
  a_r1_idle_standby: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !rsp_valid));
  // R9: a taken request selects the memory on the next cycle
  a_r9_accept_selects: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !mem_ce_n);
endmodule

// File: tb/tb_sram_ctl.sv
module tb_sram_ctl;
  localparam int CLK_NS = 10;
  localparam int TURN   = 3;

  function automatic int cdiv(input int a, input int b); return (a + b - 1) / b; endfunction
  function automatic int mx(input int a, input int b); return (a > b) ? a : b; endfunction

  localparam int AA_EXP  = cdiv(45, CLK_NS);
  localparam int RD_EXP  = mx(mx(cdiv(45, CLK_NS), cdiv(45, CLK_NS)), cdiv(25, CLK_NS));
  localparam int WR_EXP  = mx(mx(cdiv(25, CLK_NS), cdiv(20, CLK_NS)), mx(cdiv(25, CLK_NS), cdiv(45, CLK_NS) - 1));
  localparam int FLT_EXP = mx(cdiv(20, CLK_NS), TURN);

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rsp_valid, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [7:0]  rsp_data, mem_dq_out, dq_drv;
  logic [14:0] mem_addr;

  always #5 clk = ~clk;

  sram_ctl #(.CLK_PERIOD_NS(CLK_NS), .TURN_CYC(TURN)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_out(mem_dq_out), .mem_dq_in(dq_drv), .mem_dq_oe(mem_dq_oe)
  );

  int tests = 0, fails = 0;
  logic [7:0] mem   [int];
  logic [7:0] ref_m [int];

  function automatic logic [7:0] peek(input int a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction
  function automatic logic [7:0] expect_rd(input int a);
    return ref_m.exists(a) ? ref_m[a] : 8'h00;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // memory model and pin monitor, all at the falling edge
  int rd_run = 0, wr_run = 0, last_rd = 0, last_wr = 0, clash = 0;
  bit wr_end_ok = 1'b0;
  logic p_ce = 1'b1, p_we = 1'b1;
  logic [14:0] p_addr = '0;
  logic [7:0]  p_dout = '0;
  initial dq_drv = 8'hEE;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!p_ce && !p_we && (mem_ce_n || mem_we_n)) begin
        mem[int'(p_addr)] = p_dout;
        wr_end_ok = mem_ce_n && mem_we_n && mem_dq_oe;
        last_wr   = wr_run;
      end
      wr_run = (!mem_ce_n && !mem_we_n) ? wr_run + 1 : 0;
      if (!mem_we_n && !mem_dq_oe) clash++;
      if (!mem_we_n && !mem_oe_n) clash++;
      if (mem_dq_oe && !mem_oe_n) clash++;
      if (!mem_ce_n && !mem_oe_n && mem_we_n) rd_run++;
      else if (rd_run != 0) begin last_rd = rd_run; rd_run = 0; end
      dq_drv = (!mem_ce_n && !mem_oe_n && rd_run >= AA_EXP) ? peek(int'(mem_addr)) : 8'hEE;
      p_ce = mem_ce_n; p_we = mem_we_n; p_addr = mem_addr; p_dout = mem_dq_out;
    end
  end

  task automatic do_write(input logic [14:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b1; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_addr = ~a; req_wdata = ~d;   // R8: late changes ignored
    while (!req_ready) @(negedge clk);
    ref_m[int'(a)] = d;
    chk(last_wr == WR_EXP, "R5 write strobe length", last_wr, WR_EXP);
    chk(wr_end_ok, "R6 joint rise with data held", wr_end_ok, 1);
  endtask

  task automatic do_read(input logic [14:0] a, input bit hold_next);
    int n;
    logic [7:0] got;
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b0; req_addr = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_addr = ~a;
    if (hold_next) begin req_we = 1'b1; req_addr = 15'h1234; req_wdata = 8'h5A; end
    else req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    got = rsp_data;
    chk(got == expect_rd(int'(a)), "R3 read data", got, expect_rd(int'(a)));
    n = 0;
    while (!req_ready) begin
      if (n == 1) chk(!rsp_valid, "R3 single-cycle strobe", rsp_valid, 0);
      if (!mem_ce_n || !mem_we_n) begin
        chk(0, "R9 held request started early", mem_ce_n, 1);
      end
      n++;
      @(negedge clk);
    end
    chk(n == FLT_EXP, "R4 release window", n, FLT_EXP);
    chk(last_rd == RD_EXP, "R2 read select length", last_rd, RD_EXP);
    if (hold_next) begin
      @(negedge clk);
      chk(!mem_ce_n && !mem_we_n, "R9 held write taken", mem_we_n, 0);
      req_valid = 1'b0;
      while (!req_ready) @(negedge clk);
      ref_m[32'h1234] = 8'h5A;
      chk(last_wr == WR_EXP, "R9 held write length", last_wr, WR_EXP);
    end
  endtask

  task automatic finish_up();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    finish_up();
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(mem_ce_n && mem_oe_n && mem_we_n, "R1 strobes high", {mem_ce_n, mem_oe_n, mem_we_n}, 7);
    chk(!mem_dq_oe && !rsp_valid && req_ready, "R1 idle outputs",
        {mem_dq_oe, rsp_valid, req_ready}, 1);
    // directed corners
    do_read(15'h0000, 1'b0);
    do_write(15'h0000, 8'hA5);
    do_write(15'h7FFF, 8'h3C);
    do_read(15'h7FFF, 1'b0);
    do_read(15'h0000, 1'b0);
    do_write(15'h0000, 8'hFF);
    do_read(15'h0000, 1'b1);
    do_read(15'h1234, 1'b0);
    // random mix over a small window so reads hit earlier writes
    for (int i = 0; i < 150; i++) begin
      logic [14:0] a;
      a = (($urandom % 4) == 0) ? 15'($urandom) : 15'($urandom % 32);
      if ($urandom % 2) do_write(a, 8'($urandom));
      else do_read(a, 1'b0);
      // R1 between accesses
      chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe, "R1 standby between accesses",
          {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 14);
    end
    chk(clash == 0, "R7 bus contention events", clash, 0);
    finish_up();
  end
endmodule